// File: doc/BRIEF.md
# Two-Bridge PWM Current Chopper

This block regulates winding current in two H-bridges with fixed-period PWM. Each period opens with every bridge driving current. For a blanking window at the start of the period the bridge's current-trip comparator is not looked at. After that window, a trip moves the bridge into a decay phase, and the bridge stays there until the next period starts. One shared decay selector picks slow, fast or mixed decay for both bridges. In mixed decay the bridge decays fast until three quarters of the period have passed and decays slowly for the rest of the period.

The chip's three-level decay pin reaches the logic as a two-bit code that has already been resolved. An active-low reset and an active-low sleep hold both bridges off. After the block is released, it waits a wake-up delay before it raises `ready` and begins the first period. The PWM period, the blanking window and the wake delay are all counted in clock cycles. They are derived from a clock-frequency parameter. At the default 20 MHz clock the blanking window is 75 cycles, the period is 400 cycles and the wake delay is 20000 cycles.

Top module: `chop_ctrl`

## Requirements
- R1: `decay_sel` code 2'b00 selects slow decay, 2'b01 selects fast decay, and 2'b10 (open pin) or 2'b11 selects mixed decay. One code applies to every bridge, and it takes effect one cycle after it is sampled.
- R2: `ready` rises after WAKE_CYC consecutive clock edges that each see `rst_n` and `sleep_n` both high. It falls at the first edge that sees either of them low.
- R3: While `ready` is low, every bridge's drive, fast and slow flags are 0. Trip inputs seen while `ready` is low do not carry over into the first period after wake-up.
- R4: Periods are PERIOD_CYC cycles long and count positions 0 to PERIOD_CYC-1 from the first cycle with `ready` high. At position 0 every bridge is driving.
- R5: A trip sampled at a position below BLANK_CYC is ignored. Every bridge therefore drives for at least positions 0 to BLANK_CYC.
- R6: A trip sampled at position p (BLANK_CYC <= p < PERIOD_CYC-1) while the bridge is driving ends its drive from position p+1 to the end of the period. Later trip activity in the same period has no effect.
- R7: In slow mode, a decaying bridge shows only the slow flag.
- R8: In fast mode, a decaying bridge shows only the fast flag.
- R9: In mixed mode, a decaying bridge shows the fast flag at positions below 3*PERIOD_CYC/4 and the slow flag from that position onward.
- R10: While `ready` is high, each bridge shows exactly one of drive, fast and slow. Each bridge follows only its own trip input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously |
| sleep_n | input | 1 | Active-low sleep request |
| decay_sel | input | 2 | Resolved decay selector code |
| trip | input | NUM_BRIDGES | Per-bridge current comparator trip |
| ready | output | 1 | Wake-up delay done, bridges enabled |
| drive | output | NUM_BRIDGES | Bridge is in its drive phase |
| fast_decay | output | NUM_BRIDGES | Bridge is in fast decay |
| slow_decay | output | NUM_BRIDGES | Bridge is in slow decay |

## Verification
The mode assertions assume that `decay_sel` is a clean two-bit code sampled once per cycle. They relate the code seen at the previous edge to the decay flags, so a glitch that does not meet setup is outside their scope. The bench changes the code only between clock edges and keeps each code for whole periods. The blanking and period assertions rely on the position counter restarting whenever `ready` falls. For that reason the bench drops sleep and reset in the middle of a period and holds the trip inputs high during the outage. It also sweeps the trip position across every position in every code.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [1:0] {
        DK_SLOW  = 2'd0,
        DK_FAST  = 2'd1,
        DK_MIXED = 2'd2
    } decay_mode_t;

    typedef enum logic [1:0] {
        PH_OFF,
        PH_DRIVE,
        PH_FAST,
        PH_SLOW
    } bridge_phase_t;

    typedef struct packed {
        logic drive;
        logic fast;
        logic slow;
    } bridge_out_t;

    // R1: code map of the resolved three-level selector
    function automatic decay_mode_t decode_decay(input logic [1:0] code);
        case (code)
            2'b00:   return DK_SLOW;
            2'b01:   return DK_FAST;
            default: return DK_MIXED;
        endcase
    endfunction

    function automatic bridge_phase_t pick_phase(
        input logic        live,
        input logic        tripped,
        input decay_mode_t mode,
        input logic        late
    );
        if (!live)
            return PH_OFF;
        if (!tripped)
            return PH_DRIVE;
        case (mode)
            DK_SLOW: return PH_SLOW;
            DK_FAST: return PH_FAST;
            default: return late ? PH_SLOW : PH_FAST;
        endcase
    endfunction

    function automatic bridge_out_t phase_flags(input bridge_phase_t ph);
        bridge_out_t o;
        o.drive = (ph == PH_DRIVE);
        o.fast  = (ph == PH_FAST);
        o.slow  = (ph == PH_SLOW);
        return o;
    endfunction

endpackage

// File: rtl/chop_wake.sv
module chop_wake #(
    parameter int WAKE_CYC = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_n,
    output logic ready
);
    localparam int WW = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;
    localparam logic [WW-1:0] WLAST = WW'(WAKE_CYC - 1);

    logic [WW-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !sleep_n) begin
            wcnt  <= '0;
            ready <= 1'b0;
        end else if (!ready) begin
            if (wcnt == WLAST)
                ready <= 1'b1;
            else
                wcnt <= wcnt + 1'b1;
        end
    end
endmodule

// File: rtl/chop_period.sv
module chop_period #(
    parameter int PERIOD_CYC = 400,
    parameter int BLANK_CYC  = 75,
    parameter int MIX_POS    = 300,
    parameter int PW         = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ready,
    output logic [PW-1:0] pos,
    output logic          blank_open,
    output logic          late,
    output logic          last
);
    localparam logic [PW-1:0] PLAST = PW'(PERIOD_CYC - 1);
    localparam logic [PW-1:0] PBLK  = PW'(BLANK_CYC);
    localparam logic [PW-1:0] PMIX  = PW'(MIX_POS);

    always_ff @(posedge clk) begin
        if (!rst_n || !ready)
            pos <= '0;
        else if (pos == PLAST)
            pos <= '0;
        else
            pos <= pos + 1'b1;
    end

    always_comb begin
        blank_open = (pos >= PBLK);
        late       = (pos >= PMIX);
        last       = (pos == PLAST);
    end
endmodule

// File: rtl/chop_bridge.sv
module chop_bridge
    import chop_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ready,
    input  logic        blank_open,
    input  logic        late,
    input  logic        last,
    input  decay_mode_t mode,
    input  logic        trip,
    output bridge_out_t flags
);
    logic tripped;

    always_ff @(posedge clk) begin
        if (!rst_n || !ready)
            tripped <= 1'b0;
        else if (last)
            tripped <= 1'b0;
        else if (!tripped && trip && blank_open)
            tripped <= 1'b1;
    end

    always_comb flags = phase_flags(pick_phase(ready, tripped, mode, late));
endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
    import chop_pkg::*;
#(
    parameter int NUM_BRIDGES = 2,
    parameter int CLK_KHZ     = 20000,
    parameter int PWM_KHZ     = 50,
    parameter int BLANK_NS    = 3750,
    parameter int WAKE_US     = 1000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sleep_n,
    input  logic [1:0]             decay_sel,
    input  logic [NUM_BRIDGES-1:0] trip,
    output logic                   ready,
    output logic [NUM_BRIDGES-1:0] drive,
    output logic [NUM_BRIDGES-1:0] fast_decay,
    output logic [NUM_BRIDGES-1:0] slow_decay
);
    localparam int PERIOD_CYC = CLK_KHZ / PWM_KHZ;
    localparam int BLANK_CYC  = (CLK_KHZ * BLANK_NS) / 1000000;
    localparam int WAKE_CYC   = (CLK_KHZ * WAKE_US) / 1000;
    localparam int MIX_POS    = (PERIOD_CYC * 3) / 4;
    localparam int PW         = $clog2(PERIOD_CYC);

    logic [PW-1:0] period_pos;
    logic          blank_open, late, last;
    decay_mode_t   mode_q;

    chop_wake #(.WAKE_CYC(WAKE_CYC)) u_wake (
        .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .ready(ready)
    );

    chop_period #(
        .PERIOD_CYC(PERIOD_CYC), .BLANK_CYC(BLANK_CYC),
        .MIX_POS(MIX_POS), .PW(PW)
    ) u_period (
        .clk(clk), .rst_n(rst_n), .ready(ready), .pos(period_pos),
        .blank_open(blank_open), .late(late), .last(last)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= DK_MIXED;
        else
            mode_q <= decode_decay(decay_sel);
    end

    for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_bridge
        bridge_out_t fl;
        chop_bridge u_br (
            .clk(clk), .rst_n(rst_n), .ready(ready),
            .blank_open(blank_open), .late(late), .last(last),
            .mode(mode_q), .trip(trip[b]), .flags(fl)
        );
        assign drive[b]      = fl.drive;
        assign fast_decay[b] = fl.fast;
        assign slow_decay[b] = fl.slow;
    end
endmodule

// File: rtl/chop_ctrl_chk.sv
module chop_ctrl_chk #(
    parameter int N          = 2,
    parameter int BLANK_CYC  = 75,
    parameter int MIX_POS    = 300,
    parameter int PW         = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sleep_n,
    input logic [1:0]    decay_sel,
    input logic          ready,
    input logic [N-1:0]  drive,
    input logic [N-1:0]  fast_decay,
    input logic [N-1:0]  slow_decay,
    input logic [PW-1:0] pos
);
    // R2
    ready_drop_chk: assert property (@(posedge clk)
        !sleep_n |=> !ready);

    // R3
    off_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (drive == '0 && fast_decay == '0 && slow_decay == '0));

    // R4
    period_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && pos == '0) |-> (&drive));

    // R5
    blank_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && pos <= PW'(BLANK_CYC)) |-> (&drive));

    // R7
    slow_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(rst_n) && $past(decay_sel) == 2'b00) |-> (fast_decay == '0));

    // R8
    fast_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(rst_n) && $past(decay_sel) == 2'b01) |-> (slow_decay == '0));

    // R9
    mixed_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(rst_n) && $past(decay_sel[1]) && pos < PW'(MIX_POS)) |-> (slow_decay == '0));

    // R9
    mixed_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(rst_n) && $past(decay_sel[1]) && pos >= PW'(MIX_POS)) |-> (fast_decay == '0));

    for (genvar b = 0; b < N; b++) begin : g_b
        // R10
        one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ready |-> ($countones({drive[b], fast_decay[b], slow_decay[b]}) == 1));

        // R6
        no_reentry_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ready && $past(ready) && pos != '0 && !$past(drive[b])) |-> !drive[b]);
    end
endmodule

bind chop_ctrl chop_ctrl_chk #(
    .N(NUM_BRIDGES), .BLANK_CYC(BLANK_CYC), .MIX_POS(MIX_POS), .PW(PW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .decay_sel(decay_sel),
    .ready(ready), .drive(drive), .fast_decay(fast_decay),
    .slow_decay(slow_decay), .pos(period_pos)
);

// File: tb/chop_ctrl_test.sv
module chop_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NB    = 2;
    localparam int P     = 40;   // 1000 kHz / 25 kHz
    localparam int BLANK = 6;    // 1000 kHz * 6000 ns
    localparam int WAKE  = 20;   // 1000 kHz * 20 us
    localparam int MIX   = 30;   // 3/4 of P

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep_n = 1'b0;
    logic [1:0]    decay_sel = 2'b00;
    logic [NB-1:0] trip = '0;
    logic          ready;
    logic [NB-1:0] drive, fast_decay, slow_decay;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model of the requirements
    bit m_ready = 1'b0;
    int m_w = 0;
    int m_pos = 0;
    int m_mode = 2;
    bit [1:0] m_code = 2'b10;
    bit m_t [NB];

    always #(CLK_PERIOD/2) clk = ~clk;

    chop_ctrl #(
        .NUM_BRIDGES(NB), .CLK_KHZ(1000), .PWM_KHZ(25),
        .BLANK_NS(6000), .WAKE_US(20)
    ) uut (
        .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .decay_sel(decay_sel),
        .trip(trip), .ready(ready), .drive(drive),
        .fast_decay(fast_decay), .slow_decay(slow_decay)
    );

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic check_all();
        checks++;
        if (ready !== m_ready) begin
            fails++;
            $display("FAIL R2 ready: got %b expected %b", ready, m_ready);
        end
        for (int b = 0; b < NB; b++) begin
            logic [2:0] exp, got;
            string lbl;
            exp = 3'b000;
            if (!m_ready) lbl = "R3";
            else if (!m_t[b]) begin
                exp = 3'b100;
                lbl = (m_pos == 0) ? "R4" : (m_pos <= BLANK) ? "R5" : "R6";
            end else if (m_mode == 0) begin exp = 3'b001; lbl = "R7"; end
            else if (m_mode == 1) begin exp = 3'b010; lbl = "R8"; end
            else begin
                exp = (m_pos >= MIX) ? 3'b001 : 3'b010;
                lbl = (m_code == 2'b11) ? "R1" : "R9";
            end
            got = {drive[b], fast_decay[b], slow_decay[b]};
            checks++;
            if (got !== exp) begin
                fails++;
                $display("FAIL %s bridge %0d pos %0d {drive,fast,slow}: got %b expected %b",
                         lbl, b, m_pos, got, exp);
            end
            if (m_ready) begin
                checks++;
                if ($countones(got) != 1) begin
                    fails++;
                    $display("FAIL R10 bridge %0d phases: got %b expected one-hot", b, got);
                end
            end
        end
    endtask

    task automatic step(input bit rn, input bit sn, input bit [1:0] sl, input bit [NB-1:0] tr);
        bit old_ready;
        rst_n = rn; sleep_n = sn; decay_sel = sl; trip = tr;
        old_ready = m_ready;
        if (!rn || !sn) begin m_ready = 0; m_w = 0; end
        else if (!m_ready) begin
            if (m_w == WAKE - 1) m_ready = 1; else m_w++;
        end
        for (int b = 0; b < NB; b++) begin
            if (!rn || !old_ready) m_t[b] = 0;
            else if (m_pos == P - 1) m_t[b] = 0;
            else if (!m_t[b] && tr[b] && m_pos >= BLANK) m_t[b] = 1;
        end
        if (!rn || !old_ready) m_pos = 0;
        else m_pos = (m_pos == P - 1) ? 0 : m_pos + 1;
        m_mode = !rn ? 2 : (sl == 2'b00) ? 0 : (sl == 2'b01) ? 1 : 2;   // R1
        m_code = rn ? sl : 2'b10;
        @(negedge clk);
        check_all();
    endtask

    initial begin
        for (int c = 0; c < 200000; c++) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        for (int b = 0; b < NB; b++) m_t[b] = 0;
        // reset state (R3)
        for (int i = 0; i < 3; i++) step(0, 1, 2'b00, 2'b11);
        // wake-up delay (R2)
        for (int i = 0; i < WAKE; i++) step(1, 1, 2'b00, 2'b00);
        // sweep every code and trip position (R1, R4-R10)
        for (int code = 0; code < 4; code++)
            for (int tp = 0; tp < P; tp++)
                for (int k = 0; k < P; k++)
                    step(1, 1, 2'(code), {(k >= P - 1 - tp), (k == tp || k == 1)});
        // sleep mid-period with trips held (R2, R3)
        for (int i = 0; i < 13; i++) step(1, 1, 2'b10, 2'b00);
        for (int i = 0; i < 6; i++) step(1, 0, 2'b10, 2'b11);
        for (int i = 0; i < WAKE + P; i++) step(1, 1, 2'b10, 2'b11);
        // reset mid-period (R3, R4)
        for (int i = 0; i < 9; i++) step(1, 1, 2'b01, 2'b01);
        for (int i = 0; i < 2; i++) step(0, 1, 2'b01, 2'b11);
        for (int i = 0; i < WAKE + 2 * P; i++) step(1, 1, 2'b11, 2'(i % 3));
        done = 1'b1;
        finish_run();
    end
endmodule